// File: doc/BRIEF.md
# Dual-Output Programmable Clock Divider

This block derives three clocks from one of two sources. A static select picks either the nominal 12 MHz internal reference or a user-supplied clock as the source of a shared prescaler. The prescaler is a free-running binary counter. Two divided outputs are taken from its bits, each with its own ratio select. Output A uses the even-power ladder 4, 16, 64, 256. Output B uses the odd-power ladder 2, 8, 32, 128, 1024, 4096, 16384, 65536.

A third output is a configuration clock that always comes from the reference. It runs at the reference rate divided by 12, 2 or 1, which gives 1, 6 or 12 MHz.

All select codes are captured while the synchronous, active-high reset is held. Reset also clears every counter and forces all three outputs low. On release, all three outputs start again from a known phase. The source select and the ratio codes are meant to be set before reset is released and left alone after that.

Top module: `pdiv_dual_clock`

## Requirements
- R1: With `use_usr_i` = 0 the prescaler counts the reference clock; with `use_usr_i` = 1 it counts the user clock. The periods of outputs A and B are whole multiples of the chosen source period.
- R2: Output A has a period of 4, 16, 64 or 256 source cycles for `sel_a_i` = 0, 1, 2 or 3.
- R3: Output B has a period of 2, 8, 32 or 128 source cycles for `sel_b_i` = 0 to 3, and 1024, 4096, 16384 or 65536 for `sel_b_i` = 4 to 7.
- R4: Outputs A and B are high for exactly half of each period.
- R5: The configuration clock depends on `sel_cfg_i`. Code 0 divides the reference by 12 and code 1 divides it by 2. Code 2 passes the reference through, which is divide by 1. Code 3 behaves like code 0. In the divided modes the clock is high for half of its period.
- R6: While `rst_i` is held, all three outputs are low once a source edge has been seen.
- R7: Let the first source edge at which reset is seen low be edge 1. A divided output of ratio N then makes its first rising edge at source edge N/2.
- R8: The select codes are captured only while reset is held. Changing them after release has no effect on any output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Nominal 12 MHz reference clock |
| usr_clk_i | input | 1 | User-supplied clock |
| use_usr_i | input | 1 | Source select: 0 reference, 1 user clock (static) |
| rst_i | input | 1 | Synchronous active-high reset; select codes are captured while it is high |
| sel_a_i | input | 2 | Ratio code for output A |
| sel_b_i | input | 3 | Ratio code for output B |
| sel_cfg_i | input | 2 | Rate code for the configuration clock |
| div_a_o | output | 1 | Output A, even-power divided clock |
| div_b_o | output | 1 | Output B, odd-power divided clock |
| cfg_clk_o | output | 1 | Configuration clock |

## Verification
The bench targets the break in the odd ladder between code 3 (128) and code 4 (1024). A tap map that carried on in steps of two bits would give 512 there. It also runs the widest ratio, 65536, on the faster user clock, where a counter that is too short would never produce a second edge. On the configuration clock it checks the pass-through code, whose output must match the reference exactly, and the spare code, which must fall back to 1 MHz and not stop.

The restart phase is checked against the count of edges from reset release. An off-by-one in the reset value would move every first edge by one cycle. Codes are changed right after release, so a design that kept sampling them would show the new periods.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
package pdiv_pkg;

  localparam int SLOW_SEL_W  = 2;
  localparam int FAST_SEL_W  = 3;
  localparam int LADDER_EVEN = 0;
  localparam int LADDER_ODD  = 1;

  typedef enum logic [1:0] {
    RATE_SLOW     = 2'd0,
    RATE_MID      = 2'd1,
    RATE_PASS     = 2'd2,
    RATE_SLOW_ALT = 2'd3
  } cfg_rate_e;

  // Counter bit whose toggling gives the ratio picked by code.
  // Bit k of a binary counter has a period of 2^(k+1) source cycles.
  function automatic int ladder_tap(int kind, int code);
    if (kind == LADDER_EVEN) return 2 * code + 1;
    if (code < (1 << (FAST_SEL_W - 1))) return 2 * code;
    return 2 * code + 1;
  endfunction

  function automatic int prescale_width();
    return ladder_tap(LADDER_ODD, (1 << FAST_SEL_W) - 1) + 1;
  endfunction

endpackage

// File: rtl/pdiv_prescaler.sv
`timescale 1ns/1ps
module pdiv_prescaler #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  output logic [W-1:0] cnt_o
);

  wire wrap_w = &cnt_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_o <= '0;
    else       cnt_o <= cnt_o + 1'b1;
  end

  // R7: the chain restarts at zero after the all-ones state
  a_r7_wrap_restarts: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_w |=> (cnt_o == '0));

endmodule

// File: rtl/pdiv_tap_pick.sv
`timescale 1ns/1ps
module pdiv_tap_pick #(
  parameter int W      = 16,
  parameter int CODE_W = 2,
  parameter int KIND   = 0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CODE_W-1:0] sel_i,
  input  logic [W-1:0]      cnt_i,
  output logic              out_o
);

  localparam int NSEL = 1 << CODE_W;
  localparam int TW   = $clog2(W);

  logic [CODE_W-1:0] code_q;
  logic [NSEL-1:0]   taps;
  logic [TW-1:0]     tap_idx;
  logic [W-1:0]      rise_pat;
  logic [W-1:0]      rise_mask;
  wire               aligned_w;

  always_ff @(posedge clk_i) begin
    if (rst_i) code_q <= sel_i;
  end

  for (genvar i = 0; i < NSEL; i++) begin : g_tap
    assign taps[i] = cnt_i[pdiv_pkg::ladder_tap(KIND, i)];
  end

  assign out_o     = taps[code_q];
  assign tap_idx   = TW'(pdiv_pkg::ladder_tap(KIND, int'(code_q)));
  assign rise_pat  = W'(1) << tap_idx;
  assign rise_mask = (rise_pat << 1) - W'(1);
  assign aligned_w = ((cnt_i & rise_mask) == rise_pat);

  // R2 / R3: a rising edge only when the counter sits at the tap's half-period
  a_r4_rise_on_aligned_count: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(out_o) |-> aligned_w);

  // R8: ratio code is frozen once reset is released
  a_r8_code_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> $stable(code_q));

endmodule

// File: rtl/pdiv_cfg_gen.sv
`timescale 1ns/1ps
module pdiv_cfg_gen #(
  parameter int SLOW_DIV = 12,
  parameter int MID_DIV  = 2
) (
  input  logic       ref_clk_i,
  input  logic       rst_i,
  input  logic [1:0] sel_i,
  output logic       cfg_clk_o
);
  import pdiv_pkg::*;

  localparam int SLOW_HALF = SLOW_DIV / 2;
  localparam int MID_HALF  = MID_DIV / 2;
  localparam int CW        = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;

  cfg_rate_e      rate_q;
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  half_m1;
  logic           div_q;
  logic           run_q;
  wire            pass_w    = (rate_q == RATE_PASS);
  wire            at_term_w = !pass_w && (cnt_q == half_m1);

  always_comb begin
    case (rate_q)
      RATE_MID:  half_m1 = CW'(MID_HALF - 1);
      RATE_PASS: half_m1 = '0;
      default:   half_m1 = CW'(SLOW_HALF - 1);
    endcase
  end

  always_ff @(posedge ref_clk_i) begin
    if (rst_i) begin
      rate_q <= cfg_rate_e'(sel_i);
      cnt_q  <= '0;
      div_q  <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (at_term_w) begin
        cnt_q <= '0;
        div_q <= ~div_q;
      end else if (!pass_w) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cfg_clk_o = pass_w ? (ref_clk_i & run_q) : div_q;

  // R5: the divided clock changes only after a terminal count
  a_r5_toggle_at_terminal: assert property (@(posedge ref_clk_i) disable iff (rst_i)
    !$stable(div_q) |-> $past(at_term_w));

  // R5: the half-period counter never passes its limit
  a_r5_count_bounded: assert property (@(posedge ref_clk_i) disable iff (rst_i)
    cnt_q <= half_m1);

  // R6: configuration clock held low under reset
  a_r6_cfg_low_in_reset: assert property (@(posedge ref_clk_i)
    rst_i |=> !cfg_clk_o);

  // R8: rate code frozen after release
  a_r8_rate_frozen: assert property (@(posedge ref_clk_i) disable iff (rst_i)
    !rst_i |=> $stable(rate_q));

endmodule

// File: rtl/pdiv_dual_clock.sv
`timescale 1ns/1ps
module pdiv_dual_clock #(
  parameter int CFG_SLOW_DIV = 12,
  parameter int CFG_MID_DIV  = 2
) (
  input  logic       ref_clk_i,
  input  logic       usr_clk_i,
  input  logic       use_usr_i,
  input  logic       rst_i,
  input  logic [1:0] sel_a_i,
  input  logic [2:0] sel_b_i,
  input  logic [1:0] sel_cfg_i,
  output logic       div_a_o,
  output logic       div_b_o,
  output logic       cfg_clk_o
);
  import pdiv_pkg::*;

  localparam int CNT_W = prescale_width();

  logic             src_clk;
  logic [CNT_W-1:0] pre_cnt;

  assign src_clk = use_usr_i ? usr_clk_i : ref_clk_i;

  pdiv_prescaler #(.W(CNT_W)) i_pre (
    .clk_i (src_clk),
    .rst_i (rst_i),
    .cnt_o (pre_cnt)
  );

  pdiv_tap_pick #(.W(CNT_W), .CODE_W(SLOW_SEL_W), .KIND(LADDER_EVEN)) i_tap_a (
    .clk_i (src_clk),
    .rst_i (rst_i),
    .sel_i (sel_a_i),
    .cnt_i (pre_cnt),
    .out_o (div_a_o)
  );

  pdiv_tap_pick #(.W(CNT_W), .CODE_W(FAST_SEL_W), .KIND(LADDER_ODD)) i_tap_b (
    .clk_i (src_clk),
    .rst_i (rst_i),
    .sel_i (sel_b_i),
    .cnt_i (pre_cnt),
    .out_o (div_b_o)
  );

  pdiv_cfg_gen #(.SLOW_DIV(CFG_SLOW_DIV), .MID_DIV(CFG_MID_DIV)) i_cfg (
    .ref_clk_i (ref_clk_i),
    .rst_i     (rst_i),
    .sel_i     (sel_cfg_i),
    .cfg_clk_o (cfg_clk_o)
  );

  // R6: both ratio outputs low under reset
  a_r6_div_low_in_reset: assert property (@(posedge src_clk)
    rst_i |=> (!div_a_o && !div_b_o));

endmodule

// File: tb/test_pdiv_dual_clock.sv
`timescale 1ns/1ps
module test_pdiv_dual_clock;

  localparam longint REF_P = 20;
  localparam longint USR_P = 8;

  logic       ref_clk = 1'b0;
  logic       usr_clk = 1'b0;
  logic       use_usr = 1'b0;
  logic       rst     = 1'b1;
  logic [1:0] sel_a   = '0;
  logic [2:0] sel_b   = '0;
  logic [1:0] sel_cfg = '0;
  wire        div_a, div_b, cfg_clk;
  wire  [2:0] outs = {cfg_clk, div_b, div_a};

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  pdiv_dual_clock i_pdiv_dual_clock (
    .ref_clk_i (ref_clk),
    .usr_clk_i (usr_clk),
    .use_usr_i (use_usr),
    .rst_i     (rst),
    .sel_a_i   (sel_a),
    .sel_b_i   (sel_b),
    .sel_cfg_i (sel_cfg),
    .div_a_o   (div_a),
    .div_b_o   (div_b),
    .cfg_clk_o (cfg_clk)
  );

  always #10 ref_clk = ~ref_clk;
  initial begin
    #1;
    forever #4 usr_clk = ~usr_clk;
  end

  function automatic longint ratio_a(int c);
    longint r = 4;
    for (int k = 0; k < c; k++) r = r * 4;
    return r;
  endfunction

  function automatic longint ratio_b(int c);
    longint r = (c < 4) ? 2 : 1024;
    for (int k = 0; k < c % 4; k++) r = r * 4;
    return r;
  endfunction

  function automatic longint ratio_cfg(int c);
    if (c == 1) return 2;
    if (c == 2) return 1;
    return 12;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic meas(int which, output longint t1, output longint tf, output longint t2);
    wait (outs[which] == 1'b1);
    t1 = $time;
    wait (outs[which] == 1'b0);
    tf = $time;
    wait (outs[which] == 1'b1);
    t2 = $time;
  endtask

  task automatic run_case(bit usr, int a, int b, int c, bit perturb);
    longint t1[3];
    longint tf[3];
    longint t2[3];
    longint r[3];
    longint p[3];
    longint t_rel;
    string  lab[3];
    @(negedge ref_clk);
    rst     = 1'b1;
    use_usr = usr;
    sel_a   = 2'(a);
    sel_b   = 3'(b);
    sel_cfg = 2'(c);
    repeat (4) @(negedge ref_clk);
    check("R6", "outputs under reset", longint'(outs), 0);
    rst   = 1'b0;
    t_rel = $time;
    if (perturb) begin
      #3;
      sel_a   = ~sel_a;
      sel_b   = sel_b + 3'd3;
      sel_cfg = (c == 2) ? 2'd0 : 2'd2;
    end
    fork
      meas(0, t1[0], tf[0], t2[0]);
      meas(1, t1[1], tf[1], t2[1]);
      meas(2, t1[2], tf[2], t2[2]);
    join
    r[0] = ratio_a(a);
    r[1] = ratio_b(b);
    r[2] = ratio_cfg(c);
    p[0] = usr ? USR_P : REF_P;
    p[1] = p[0];
    p[2] = REF_P;
    lab[0] = perturb ? "R8 R2" : (usr ? "R1 R2" : "R2");
    lab[1] = perturb ? "R8 R3" : (usr ? "R1 R3" : "R3");
    lab[2] = perturb ? "R8 R5" : "R5";
    check(lab[0], "period A ns", t2[0] - t1[0], r[0] * p[0]);
    check(lab[1], "period B ns", t2[1] - t1[1], r[1] * p[1]);
    check(lab[2], "period cfg ns", t2[2] - t1[2], r[2] * p[2]);
    check("R4", "high time A ns", tf[0] - t1[0], r[0] * p[0] / 2);
    check("R4", "high time B ns", tf[1] - t1[1], r[1] * p[1] / 2);
    check("R5", "high time cfg ns", tf[2] - t1[2], r[2] * p[2] / 2);
    if (!usr) begin
      for (int k = 0; k < 3; k++) begin
        if (r[k] > 1)
          check("R7", "first rise after release ns", t1[k] - t_rel,
                REF_P / 2 + (r[k] / 2 - 1) * REF_P);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge ref_clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge ref_clk);
    // directed: every code of each ladder, both sources
    run_case(1'b0, 0, 0, 0, 1'b0);
    run_case(1'b0, 1, 1, 1, 1'b0);
    run_case(1'b0, 2, 2, 2, 1'b0);
    run_case(1'b0, 3, 3, 3, 1'b0);
    run_case(1'b0, 0, 4, 0, 1'b0);
    run_case(1'b0, 1, 5, 1, 1'b0);
    run_case(1'b1, 2, 6, 2, 1'b0);
    run_case(1'b1, 3, 7, 0, 1'b0);
    // R8: codes changed after release must be ignored
    run_case(1'b0, 1, 2, 1, 1'b1);
    run_case(1'b0, 2, 1, 2, 1'b1);
    // random mix
    for (int n = 0; n < 5; n++) begin
      run_case(1'($urandom % 2), int'($urandom % 4), int'($urandom % 6),
               int'($urandom % 4), 1'b0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule